// File: doc/BRIEF.md
# Temperature-Curve Fan PWM Controller

The block converts periodic temperature samples into a fan drive signal. Each sample is an unsigned 12-bit value in whole degrees Celsius. It enters on a one-cycle valid strobe, so the upstream logic sets the sample rate. A short table of programmable temperature knots and matching duty levels defines a piecewise-linear curve. Below the lowest knot the duty stays at the first level. Between knots it is interpolated with integer arithmetic that truncates toward zero. Above the highest knot it steps straight to full speed.

The chosen duty, in percent, drives a PWM counter with a period of 100 clock cycles, so one duty unit equals one high cycle. A new duty value is applied only when a period begins. An over-temperature threshold raises a flag and forces full speed. A tachometer monitor latches a stall alarm when no rising tach edge arrives within a programmable number of cycles while the fan is being driven. A write to a dedicated register address clears the alarm.

Top module: `fan_ctrl`

## Requirements
- R1: After reset, pwm_out, duty_pct, ot_flag and stall_alarm are all 0. Reset defaults are: knots 40/50/60/70, levels 20/40/60/80, over-temperature threshold 85, stall timeout 5000.
- R2: A sample below the first knot gives the first duty level (20 by default).
- R3: A sample between knot k and knot k+1, inclusive, gives d_k + (T - t_k)*(d_{k+1} - d_k)/(t_k+1 - t_k), with the quotient truncated.
- R4: A sample equal to the top knot gives the top level. A sample above the top knot gives 100.
- R5: The applied duty never exceeds 100. In each 100-cycle PWM period, pwm_out is high for exactly duty_pct cycles, starting at the first cycle of the period.
- R6: A new sample changes duty_pct and the PWM high time only from the next period start. The period already running keeps its old duty.
- R7: Writes with wr_en set and the following addresses reprogram the curve: 0..3 set knot temperatures (wr_data[11:0]), 4..7 set duty levels (wr_data[6:0]), 8 sets the over-temperature threshold (wr_data[11:0]), 9 sets the stall timeout (wr_data[15:0]).
- R8: When the held sample is at or above the threshold, ot_flag is 1 in the next cycle and the applied duty becomes 100.
- R9: While the applied duty is nonzero and no rising tach edge is seen for more than the timeout count of cycles, stall_alarm rises. While the applied duty is 0 it does not rise.
- R10: stall_alarm stays at 1 even after tach edges resume, until a write to address 10 clears it.
- R11: Decreasing segments are allowed, and the quotient rounds toward zero. With levels 50 then 21 over knots 40 and 50, a sample of 41 gives 48.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | One-cycle strobe that loads smp_temp |
| smp_temp | input | 12 | Temperature sample in degrees Celsius |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 16 | Register write data |
| tach_in | input | 1 | Fan tachometer pulse input (asynchronous) |
| pwm_out | output | 1 | Fan PWM drive |
| duty_pct | output | 7 | Duty applied in the current PWM period, 0..100 |
| ot_flag | output | 1 | Over-temperature indication |
| stall_alarm | output | 1 | Latched fan stall alarm |

## Verification
The bench checks the curve with the following sample temperatures:
- values below, on and between each knot;
- values on each side of the top knot and the threshold;
- sample pairs whose exact quotient has a fraction, so that truncation is separated from rounding.

A reprogrammed top knot separates programmable knots from fixed constants. A descending segment separates truncation toward zero from flooring. A sample change in the middle of a period, with the high cycles counted in that period and in the next one, separates period-aligned update from immediate update. For stall detection, a stopped tach is tried with the fan driven and with the fan at zero duty, and tach edges then resume while the alarm is set. These cases separate "timed out" from "not driven" and "latched" from "live".

// File: rtl/fan_pkg.sv
package fan_pkg;
    localparam int TEMP_W    = 12;
    localparam int DUTY_W    = 7;
    localparam int FULL_DUTY = 100;

    typedef logic [TEMP_W-1:0] temp_t;
    typedef logic [DUTY_W-1:0] duty_t;
endpackage

// File: rtl/fan_regs.sv
module fan_regs
    import fan_pkg::*;
#(
    parameter int NBP     = 4,
    parameter int TO_W    = 16,
    parameter int AW      = 4,
    parameter int KNOT0   = 40,
    parameter int KSTEP   = 10,
    parameter int LVL0    = 20,
    parameter int LSTEP   = 20,
    parameter int OT_DEF  = 85,
    parameter int TO_DEF  = 5000
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [AW-1:0]               wr_addr,
    input  logic [TO_W-1:0]             wr_data,
    output logic [NBP-1:0][TEMP_W-1:0]  knot_o,
    output logic [NBP-1:0][DUTY_W-1:0]  lvl_o,
    output temp_t                       ot_thr_o,
    output logic [TO_W-1:0]             timeout_o,
    output logic                        clr_o
);
    localparam int A_OT  = 2 * NBP;
    localparam int A_TO  = 2 * NBP + 1;
    localparam int A_CLR = 2 * NBP + 2;

    typedef struct packed {
        logic [NBP-1:0][TEMP_W-1:0] knot;
        logic [NBP-1:0][DUTY_W-1:0] lvl;
        temp_t                      ot;
        logic [TO_W-1:0]            tmo;
        logic                       clr;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    function automatic cfg_t cfg_init();
        cfg_t c;
        for (int i = 0; i < NBP; i++) begin
            c.knot[i] = TEMP_W'(KNOT0 + i * KSTEP);
            c.lvl[i]  = DUTY_W'(LVL0 + i * LSTEP);
        end
        c.ot  = TEMP_W'(OT_DEF);
        c.tmo = TO_W'(TO_DEF);
        c.clr = 1'b0;
        return c;
    endfunction

    always_comb begin
        cfg_d     = cfg_q;
        cfg_d.clr = 1'b0;
        if (wr_en) begin
            for (int i = 0; i < NBP; i++) begin
                if (wr_addr == AW'(i))       cfg_d.knot[i] = wr_data[TEMP_W-1:0];
                if (wr_addr == AW'(NBP + i)) cfg_d.lvl[i]  = wr_data[DUTY_W-1:0];
            end
            if (wr_addr == AW'(A_OT))  cfg_d.ot  = wr_data[TEMP_W-1:0];
            if (wr_addr == AW'(A_TO))  cfg_d.tmo = wr_data;
            if (wr_addr == AW'(A_CLR)) cfg_d.clr = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= cfg_init();
        else        cfg_q <= cfg_d;
    end

    assign knot_o    = cfg_q.knot;
    assign lvl_o     = cfg_q.lvl;
    assign ot_thr_o  = cfg_q.ot;
    assign timeout_o = cfg_q.tmo;
    assign clr_o     = cfg_q.clr;
endmodule

// File: rtl/fan_curve.sv
module fan_curve
    import fan_pkg::*;
#(
    parameter int NBP = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        smp_valid,
    input  temp_t                       smp_temp,
    input  logic [NBP-1:0][TEMP_W-1:0]  knot_i,
    input  logic [NBP-1:0][DUTY_W-1:0]  lvl_i,
    input  temp_t                       ot_thr_i,
    output duty_t                       target_o,
    output logic                        ot_o
);
    typedef struct packed {
        temp_t temp;
    } smp_t;

    smp_t s_d, s_q;
    int   seg_val [NBP-1];
    int   pick;

    function automatic int lerp(int t, int t0, int t1, int d0, int d1);
        if (t1 <= t0) return d0;
        return d0 + ((t - t0) * (d1 - d0)) / (t1 - t0);
    endfunction

    always_comb begin
        s_d = s_q;
        if (smp_valid) s_d.temp = smp_temp;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    for (genvar g = 0; g < NBP - 1; g++) begin : g_seg
        assign seg_val[g] = lerp(int'(s_q.temp), int'(knot_i[g]), int'(knot_i[g+1]),
                                 int'(lvl_i[g]), int'(lvl_i[g+1]));
    end

    assign ot_o = (s_q.temp >= ot_thr_i);

    always_comb begin
        pick = FULL_DUTY;
        for (int i = NBP - 2; i >= 0; i--) begin
            if (s_q.temp <= knot_i[i+1]) pick = seg_val[i];
        end
        if (s_q.temp < knot_i[0]) pick = int'(lvl_i[0]);
        if (ot_o)                 pick = FULL_DUTY;
        if (pick > FULL_DUTY)     pick = FULL_DUTY;
        if (pick < 0)             pick = 0;
    end

    assign target_o = DUTY_W'(pick);

    a_r8_ot_forces_full: assert property (@(posedge clk) disable iff (!rst_n)
        ot_o |-> (target_o == DUTY_W'(FULL_DUTY)));
    a_r5_target_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        target_o <= DUTY_W'(FULL_DUTY));
endmodule

// File: rtl/fan_pwm.sv
module fan_pwm
    import fan_pkg::*;
#(
    parameter int PERIOD = 100
) (
    input  logic  clk,
    input  logic  rst_n,
    input  duty_t target_i,
    output duty_t duty_o,
    output logic  pwm_o
);
    localparam int CNT_W = $clog2(PERIOD);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        duty_t            duty;
    } pwm_t;

    pwm_t p_d, p_q;

    always_comb begin
        p_d = p_q;
        if (p_q.cnt == CNT_W'(PERIOD - 1)) begin
            p_d.cnt  = '0;
            p_d.duty = target_i;
        end else begin
            p_d.cnt = p_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    assign duty_o = p_q.duty;
    assign pwm_o  = ({1'b0, p_q.cnt} < {1'b0, p_q.duty});

    a_r6_duty_held_in_period: assert property (@(posedge clk) disable iff (!rst_n)
        (p_q.cnt != '0) |-> $stable(p_q.duty));
    a_r5_cnt_in_period: assert property (@(posedge clk) disable iff (!rst_n)
        int'(p_q.cnt) < PERIOD);
endmodule

// File: rtl/fan_stall.sv
module fan_stall #(
    parameter int TO_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tach_i,
    input  logic            active_i,
    input  logic [TO_W-1:0] timeout_i,
    input  logic            clr_i,
    output logic            alarm_o
);
    typedef struct packed {
        logic [1:0]      sync;
        logic            prev;
        logic [TO_W-1:0] cnt;
        logic            alarm;
    } st_t;

    st_t s_d, s_q;
    logic tach_rise;

    assign tach_rise = s_q.sync[1] & ~s_q.prev;

    always_comb begin
        s_d      = s_q;
        s_d.sync = {s_q.sync[0], tach_i};
        s_d.prev = s_q.sync[1];
        if (!active_i || tach_rise)  s_d.cnt = '0;
        else if (s_q.cnt < timeout_i) s_d.cnt = s_q.cnt + 1'b1;
        if (active_i && s_q.cnt >= timeout_i) s_d.alarm = 1'b1;
        if (clr_i) begin
            s_d.alarm = 1'b0;
            s_d.cnt   = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign alarm_o = s_q.alarm;

    a_r10_alarm_latched: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.alarm && !clr_i) |=> s_q.alarm);
    a_r9_alarm_needs_drive: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.alarm) |-> $past(active_i));
endmodule

// File: rtl/fan_ctrl.sv
module fan_ctrl
    import fan_pkg::*;
#(
    parameter int NBP    = 4,
    parameter int PERIOD = 100,
    parameter int TO_W   = 16,
    parameter int ADDR_W = $clog2(2 * NBP + 3)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_valid,
    input  logic [11:0]       smp_temp,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [TO_W-1:0]   wr_data,
    input  logic              tach_in,
    output logic              pwm_out,
    output logic [6:0]        duty_pct,
    output logic              ot_flag,
    output logic              stall_alarm
);
    logic [NBP-1:0][TEMP_W-1:0] knot;
    logic [NBP-1:0][DUTY_W-1:0] lvl;
    temp_t                      ot_thr;
    logic [TO_W-1:0]            timeout;
    logic                       clr;
    duty_t                      target;

    fan_regs #(.NBP(NBP), .TO_W(TO_W), .AW(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .knot_o(knot), .lvl_o(lvl), .ot_thr_o(ot_thr), .timeout_o(timeout), .clr_o(clr)
    );

    fan_curve #(.NBP(NBP)) u_curve (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_temp(smp_temp),
        .knot_i(knot), .lvl_i(lvl), .ot_thr_i(ot_thr), .target_o(target), .ot_o(ot_flag)
    );

    fan_pwm #(.PERIOD(PERIOD)) u_pwm (
        .clk(clk), .rst_n(rst_n), .target_i(target), .duty_o(duty_pct), .pwm_o(pwm_out)
    );

    fan_stall #(.TO_W(TO_W)) u_stall (
        .clk(clk), .rst_n(rst_n), .tach_i(tach_in), .active_i(duty_pct != '0),
        .timeout_i(timeout), .clr_i(clr), .alarm_o(stall_alarm)
    );
endmodule

// File: tb/fan_ctrl_tb.sv
module fan_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_valid = 1'b0;
    logic [11:0] smp_temp = '0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        tach_in = 1'b0;
    logic        tach_en = 1'b1;
    logic        pwm_out, ot_flag, stall_alarm;
    logic [6:0]  duty_pct;

    int n_run = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    fan_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_temp(smp_temp),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .tach_in(tach_in),
        .pwm_out(pwm_out), .duty_pct(duty_pct), .ot_flag(ot_flag), .stall_alarm(stall_alarm)
    );

    initial begin
        forever begin
            repeat (20) @(negedge clk);
            if (tach_en) tach_in = ~tach_in;
        end
    end

    localparam int NV = 14;
    localparam int VT [NV] = '{10, 39, 40, 43, 47, 50, 55, 59, 69, 70, 71, 84, 85, 90};
    localparam int VD [NV] = '{20, 20, 20, 26, 34, 40, 50, 58, 78, 80, 100, 100, 100, 100};
    localparam string VR [NV] = '{"R2", "R2", "R3", "R3", "R3", "R3", "R3", "R3", "R3",
                                  "R4", "R4", "R4", "R8", "R8"};

    task automatic check(string req, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(int addr, int data);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 4'(addr); wr_data = 16'(data);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic smp(int t);
        @(negedge clk);
        smp_valid = 1'b1; smp_temp = 12'(t);
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    task automatic settle();
        repeat (205) @(negedge clk);
    endtask

    task automatic sync_period();
        @(posedge pwm_out);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 pwm", int'(pwm_out), 0);
        check("R1 duty", int'(duty_pct), 0);
        check("R1 ot", int'(ot_flag), 0);
        check("R1 alarm", int'(stall_alarm), 0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            smp(VT[i]);
            check(VR[i], int'(ot_flag), (VT[i] >= 85) ? 1 : 0);
            settle();
            check(VR[i], int'(duty_pct), VD[i]);
        end

        // R5 / R6: a mid-period sample change, with high cycles counted per period
        smp(45);
        settle();
        sync_period();
        begin
            int hi = 0;
            for (int i = 0; i < 100; i++) begin
                if (pwm_out) hi++;
                if (i == 5) begin smp_valid = 1'b1; smp_temp = 12'd55; end
                if (i == 6) smp_valid = 1'b0;
                if (i == 50) check("R6 held mid-period", int'(duty_pct), 30);
                if (i < 99) @(negedge clk);
            end
            check("R5 high count old", hi, 30);
            @(negedge clk);
            hi = 0;
            for (int i = 0; i < 100; i++) begin
                if (pwm_out) hi++;
                @(negedge clk);
            end
            check("R6 high count new", hi, 50);
            check("R6 duty new", int'(duty_pct), 50);
        end

        // R7: reprogram top knot to 80
        wr(3, 80);
        smp(71); settle();
        check("R7 knot moved 71", int'(duty_pct), 71);
        smp(75); settle();
        check("R7 knot moved 75", int'(duty_pct), 75);
        wr(3, 70);

        // R8: lower threshold
        wr(8, 60);
        smp(62);
        check("R8 flag low thr", int'(ot_flag), 1);
        settle();
        check("R8 full duty", int'(duty_pct), 100);
        wr(8, 85);
        smp(62);
        check("R8 flag clears", int'(ot_flag), 0);

        // R11: descending segment, truncation toward zero
        wr(4, 50); wr(5, 21);
        smp(41); settle();
        check("R11 descending trunc", int'(duty_pct), 48);
        wr(4, 20); wr(5, 40);

        // R9 / R10: stall detection with the fan driven
        smp(45); settle();
        wr(9, 50);
        tach_en = 1'b0;
        repeat (5) @(negedge clk);
        wr(10, 0);
        repeat (30) @(negedge clk);
        check("R9 no alarm early", int'(stall_alarm), 0);
        repeat (40) @(negedge clk);
        check("R9 alarm on stop", int'(stall_alarm), 1);
        tach_en = 1'b1;
        repeat (200) @(negedge clk);
        check("R10 alarm latched", int'(stall_alarm), 1);
        wr(10, 0);
        repeat (200) @(negedge clk);
        check("R10 alarm cleared", int'(stall_alarm), 0);

        // R9: zero duty does not raise the alarm
        wr(4, 0); wr(5, 0);
        smp(10); settle();
        check("R9 zero duty", int'(duty_pct), 0);
        tach_en = 1'b0;
        repeat (5) @(negedge clk);
        wr(10, 0);
        repeat (200) @(negedge clk);
        check("R9 idle no alarm", int'(stall_alarm), 0);
        check("R5 pwm low at zero", int'(pwm_out), 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule